// File: doc/BRIEF.md
# Switch-Selected Three-Layer Frame Compositor

This block builds one progressive output frame, by default 1920×1080, from three pixel streams. Layer 0 supplies a full-frame background, such as a colour bar. Layers 1 and 2 carry video. Pixels are 24 bits wide and hold three 8-bit colour planes side by side. A two-bit layout selector is normally wired to user switches. It chooses one of three layouts:

- a thumbnail layout, with both video layers at reduced size over the background;
- layer 1 alone, filling the frame;
- layer 2 alone at its native size, anchored at the top-left corner, with the background visible around it.

Overlay is opaque. Where no enabled layer covers a pixel, the background pixel is output.

Every stream uses a valid/ready handshake and carries pixels in raster order. The output counts raster positions itself and marks the first and last pixel of each frame. An enabled video layer gives up exactly the pixels that fall inside its rectangle, in raster order. A disabled layer is drained continuously, so a source that is not on screen never stalls the output. The layout and the layer-2 size are captured only while the output waits at the frame origin. A frame therefore never shows a mix of two layouts.

Top module: `mlc_compositor`

## Requirements
- R1: The output walks a frame of FRAME_W×FRAME_H pixels in raster order. `out_sof` is high exactly at position (0,0) and `out_eof` exactly at (FRAME_W-1, FRAME_H-1). After the last pixel is accepted, the next position is (0,0).
- R2: Any output pixel not covered by an enabled video layer carries the background pixel.
- R3: Where enabled rectangles overlap, layer 2 wins over layer 1, and layer 1 wins over the background.
- R4: With `mode_sw[0]`=0 (thumbnail), both video layers are enabled with size THUMB_W×THUMB_H. Layer 1 sits at (THUMB1_X, THUMB_Y) and layer 2 at (THUMB2_X, THUMB_Y).
- R5: With `mode_sw`=2'b01, layer 1 is enabled at (0,0) covering the whole frame, and layer 2 is disabled.
- R6: With `mode_sw`=2'b11, layer 2 is enabled at (0,0) with size `l2_w`×`l2_h`. Each dimension is clamped to the frame size. Layer 1 is disabled, and the background shows outside layer 2.
- R7: A disabled layer holds its ready high, and its accepted pixels have no effect on the output.
- R8: The layout selector and the layer-2 size are sampled on every cycle in which the output sits at (0,0) without a transfer. They are frozen from the transfer of pixel (0,0) until the transfer of the frame's last pixel.
- R9: `out_valid` is high only when the background and every layer covering the current position are valid. Background and enabled-layer inputs are accepted only in the cycle the output pixel is accepted. A stalled output other than the frame-origin pixel holds its data.
- R10: An enabled layer delivers its pixels in the order they are consumed: the n-th pixel taken from it inside its rectangle is the n-th pixel it offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sw | input | 2 | Layout selector: bit 0 = single view, bit 1 = pick layer 2 in single view |
| l2_w | input | clog2(FRAME_W+1) | Native width of layer 2 |
| l2_h | input | clog2(FRAME_H+1) | Native height of layer 2 |
| bg_valid | input | 1 | Background pixel valid |
| bg_ready | output | 1 | Background pixel accepted |
| bg_data | input | PIX_W | Background pixel |
| l1_valid | input | 1 | Layer 1 pixel valid |
| l1_ready | output | 1 | Layer 1 pixel accepted |
| l1_data | input | PIX_W | Layer 1 pixel |
| l2_valid | input | 1 | Layer 2 pixel valid |
| l2_ready | output | 1 | Layer 2 pixel accepted |
| l2_data | input | PIX_W | Layer 2 pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output pixel |
| out_data | output | PIX_W | Composited pixel |
| out_sof | output | 1 | Current output position is the frame origin |
| out_eof | output | 1 | Current output position is the last pixel of the frame |

## Verification
A wrong raster position or captured layout shows up in the very next output cycle. The output pulls the wrong source, the layer ready lines take the wrong pattern, or the frame markers move. Each source pixel carries its layer number and a running count, so one pixel consumed too many or too few breaks the expected count on every later pixel from that layer. Detection is therefore immediate and stays visible. Layout changes made mid-frame and while the output waits at the origin are the cases that expose a capture window that is too wide or too narrow.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  typedef enum logic [1:0] {
    LAYOUT_THUMB = 2'd0,
    LAYOUT_SOLO1 = 2'd1,
    LAYOUT_SOLO2 = 2'd2
  } layout_e;

  localparam int unsigned FIRST_VIDEO = 1;
  localparam int unsigned LAST_VIDEO  = 2;

  function automatic layout_e decode_switches(input logic [1:0] sw);
    if (!sw[0])     return LAYOUT_THUMB;
    else if (!sw[1]) return LAYOUT_SOLO1;
    else             return LAYOUT_SOLO2;
  endfunction
endpackage

// File: rtl/mlc_raster_ctr.sv
module mlc_raster_ctr #(
  parameter int unsigned FRAME_W = 1920,
  parameter int unsigned FRAME_H = 1080,
  parameter int unsigned XW      = 11,
  parameter int unsigned YW      = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [XW-1:0] pos_x,
  output logic [YW-1:0] pos_y,
  output logic          at_origin,
  output logic          at_last
);
  localparam logic [XW-1:0] X_LAST = XW'(FRAME_W - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(FRAME_H - 1);

  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;
  logic          end_of_line;

  assign end_of_line = (x_q == X_LAST);

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (adv) begin
      if (end_of_line) begin
        x_d = '0;
        y_d = (y_q == Y_LAST) ? '0 : y_q + 1'b1;
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (adv) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign pos_x     = x_q;
  assign pos_y     = y_q;
  assign at_origin = (x_q == '0) && (y_q == '0);
  assign at_last   = end_of_line && (y_q == Y_LAST);
endmodule

// File: rtl/mlc_layout_dec.sv
module mlc_layout_dec
  import mlc_pkg::*;
#(
  parameter int unsigned FRAME_W  = 1920,
  parameter int unsigned FRAME_H  = 1080,
  parameter int unsigned THUMB_W  = 640,
  parameter int unsigned THUMB_H  = 360,
  parameter int unsigned THUMB1_X = 320,
  parameter int unsigned THUMB2_X = 960,
  parameter int unsigned THUMB_Y  = 360,
  parameter int unsigned XW       = 11,
  parameter int unsigned YW       = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [1:0]          mode_sw,
  input  logic [XW-1:0]       l2_w,
  input  logic [YW-1:0]       l2_h,
  output layout_e             act_layout,
  output logic [2:1]          rect_en,
  output logic [2:1][XW-1:0]  rect_x,
  output logic [2:1][YW-1:0]  rect_y,
  output logic [2:1][XW-1:0]  rect_w,
  output logic [2:1][YW-1:0]  rect_h
);
  localparam logic [XW-1:0] FULL_W = XW'(FRAME_W);
  localparam logic [YW-1:0] FULL_H = YW'(FRAME_H);

  layout_e       lay_q, lay_d;
  logic [XW-1:0] w2_q, w2_d;
  logic [YW-1:0] h2_q, h2_d;

  always_comb begin
    lay_d = decode_switches(mode_sw);
    w2_d  = (l2_w > FULL_W) ? FULL_W : l2_w;
    h2_d  = (l2_h > FULL_H) ? FULL_H : l2_h;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lay_q <= LAYOUT_THUMB;
      w2_q  <= '0;
      h2_q  <= '0;
    end else if (capture) begin
      lay_q <= lay_d;
      w2_q  <= w2_d;
      h2_q  <= h2_d;
    end
  end

  always_comb begin
    rect_en = '0;
    rect_x  = '0;
    rect_y  = '0;
    rect_w  = '0;
    rect_h  = '0;
    unique case (lay_q)
      LAYOUT_SOLO1: begin
        rect_en[1] = 1'b1;
        rect_w[1]  = FULL_W;
        rect_h[1]  = FULL_H;
      end
      LAYOUT_SOLO2: begin
        rect_en[2] = 1'b1;
        rect_w[2]  = w2_q;
        rect_h[2]  = h2_q;
      end
      default: begin
        rect_en    = 2'b11;
        rect_x[1]  = XW'(THUMB1_X);
        rect_x[2]  = XW'(THUMB2_X);
        rect_y[1]  = YW'(THUMB_Y);
        rect_y[2]  = YW'(THUMB_Y);
        rect_w[1]  = XW'(THUMB_W);
        rect_w[2]  = XW'(THUMB_W);
        rect_h[1]  = YW'(THUMB_H);
        rect_h[2]  = YW'(THUMB_H);
      end
    endcase
  end

  assign act_layout = lay_q;
endmodule

// File: rtl/mlc_rect_hit.sv
module mlc_rect_hit #(
  parameter int unsigned XW = 11,
  parameter int unsigned YW = 11
) (
  input  logic          en,
  input  logic [XW-1:0] px,
  input  logic [YW-1:0] py,
  input  logic [XW-1:0] rx,
  input  logic [YW-1:0] ry,
  input  logic [XW-1:0] rw,
  input  logic [YW-1:0] rh,
  output logic          hit
);
  logic [XW:0] x_end;
  logic [YW:0] y_end;
  logic        in_x, in_y;

  assign x_end = {1'b0, rx} + {1'b0, rw};
  assign y_end = {1'b0, ry} + {1'b0, rh};
  assign in_x  = (px >= rx) && ({1'b0, px} < x_end);
  assign in_y  = (py >= ry) && ({1'b0, py} < y_end);
  assign hit   = en && in_x && in_y;
endmodule

// File: rtl/mlc_compositor.sv
module mlc_compositor
  import mlc_pkg::*;
#(
  parameter int unsigned FRAME_W  = 1920,
  parameter int unsigned FRAME_H  = 1080,
  parameter int unsigned PIX_W    = 24,
  parameter int unsigned THUMB_W  = 640,
  parameter int unsigned THUMB_H  = 360,
  parameter int unsigned THUMB1_X = 320,
  parameter int unsigned THUMB2_X = 960,
  parameter int unsigned THUMB_Y  = 360,
  localparam int unsigned XW      = $clog2(FRAME_W + 1),
  localparam int unsigned YW      = $clog2(FRAME_H + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sw,
  input  logic [XW-1:0]    l2_w,
  input  logic [YW-1:0]    l2_h,
  input  logic             bg_valid,
  output logic             bg_ready,
  input  logic [PIX_W-1:0] bg_data,
  input  logic             l1_valid,
  output logic             l1_ready,
  input  logic [PIX_W-1:0] l1_data,
  input  logic             l2_valid,
  output logic             l2_ready,
  input  logic [PIX_W-1:0] l2_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eof
);
  logic [XW-1:0]      pos_x;
  logic [YW-1:0]      pos_y;
  logic               at_origin, at_last;
  logic               fire, capture;
  layout_e            act_layout;
  logic [2:1]         rect_en;
  logic [2:1][XW-1:0] rect_x, rect_w;
  logic [2:1][YW-1:0] rect_y, rect_h;
  logic [2:1]         covers;
  logic [2:1]         lay_valid;
  logic [2:1]         lay_ready;

  // Layout may only change while no pixel of the frame has left yet.
  assign capture = at_origin && !fire;

  mlc_raster_ctr #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .XW(XW), .YW(YW)
  ) u_raster (
    .clk(clk), .rst_n(rst_n), .adv(fire),
    .pos_x(pos_x), .pos_y(pos_y),
    .at_origin(at_origin), .at_last(at_last)
  );

  mlc_layout_dec #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
    .THUMB_W(THUMB_W), .THUMB_H(THUMB_H),
    .THUMB1_X(THUMB1_X), .THUMB2_X(THUMB2_X), .THUMB_Y(THUMB_Y),
    .XW(XW), .YW(YW)
  ) u_layout (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .mode_sw(mode_sw), .l2_w(l2_w), .l2_h(l2_h),
    .act_layout(act_layout), .rect_en(rect_en),
    .rect_x(rect_x), .rect_y(rect_y), .rect_w(rect_w), .rect_h(rect_h)
  );

  assign lay_valid = {l2_valid, l1_valid};

  for (genvar g = FIRST_VIDEO; g <= LAST_VIDEO; g++) begin : g_layer
    mlc_rect_hit #(.XW(XW), .YW(YW)) u_hit (
      .en(rect_en[g]), .px(pos_x), .py(pos_y),
      .rx(rect_x[g]), .ry(rect_y[g]), .rw(rect_w[g]), .rh(rect_h[g]),
      .hit(covers[g])
    );
    // Disabled layers drain freely; enabled ones move with the output.
    assign lay_ready[g] = rect_en[g] ? (covers[g] && fire) : 1'b1;
  end

  always_comb begin
    out_valid = bg_valid;
    for (int k = FIRST_VIDEO; k <= LAST_VIDEO; k++) begin
      if (covers[k] && !lay_valid[k]) out_valid = 1'b0;
    end
  end

  assign fire = out_valid && out_ready;

  always_comb begin
    if (covers[2])      out_data = l2_data;
    else if (covers[1]) out_data = l1_data;
    else                out_data = bg_data;
  end

  assign bg_ready = fire;
  assign l1_ready = lay_ready[1];
  assign l2_ready = lay_ready[2];
  assign out_sof  = at_origin;
  assign out_eof  = at_last;
endmodule

// File: rtl/mlc_compositor_chk.sv
module mlc_compositor_chk
  import mlc_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_sof,
  input logic             out_eof,
  input logic [PIX_W-1:0] out_data,
  input logic             bg_ready,
  input logic             l1_ready,
  input logic             l2_ready,
  input layout_e          act_layout
);
  AST_EOF_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eof) |=> out_sof); // R1

  AST_BG_TAKEN_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    bg_ready |-> (out_valid && out_ready)); // R9

  AST_LAYOUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !out_sof |-> $stable(act_layout)); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !out_sof) |=> (out_valid && $stable(out_data))); // R9

  AST_SOLO1_DRAINS_L2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_layout == LAYOUT_SOLO1) |-> l2_ready); // R7

  AST_SOLO2_DRAINS_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_layout == LAYOUT_SOLO2) |-> l1_ready); // R7
endmodule

bind mlc_compositor mlc_compositor_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data),
  .bg_ready(bg_ready), .l1_ready(l1_ready), .l2_ready(l2_ready),
  .act_layout(act_layout)
);

// File: tb/mlc_compositor_tb_top.sv
module mlc_compositor_tb_top;
  localparam int FW = 16, FH = 8, TW = 6, TH = 3, T1X = 2, T2X = 6, TY = 3;
  localparam int XW = $clog2(FW + 1), YW = $clog2(FH + 1);

  logic          clk, rst_n;
  logic [1:0]    mode_sw;
  logic [XW-1:0] l2_w;
  logic [YW-1:0] l2_h;
  logic          bg_valid, l1_valid, l2_valid, bg_ready, l1_ready, l2_ready;
  logic [23:0]   bg_data, l1_data, l2_data, out_data;
  logic          out_valid, out_ready, out_sof, out_eof;

  mlc_compositor #(
    .FRAME_W(FW), .FRAME_H(FH), .PIX_W(24), .THUMB_W(TW), .THUMB_H(TH),
    .THUMB1_X(T1X), .THUMB2_X(T2X), .THUMB_Y(TY)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sw(mode_sw), .l2_w(l2_w), .l2_h(l2_h),
    .bg_valid(bg_valid), .bg_ready(bg_ready), .bg_data(bg_data),
    .l1_valid(l1_valid), .l1_ready(l1_ready), .l1_data(l1_data),
    .l2_valid(l2_valid), .l2_ready(l2_ready), .l2_data(l2_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 0;
  // Behavioural model state
  int mx = 0, my = 0, mlay = 0, mw2 = 0, mh2 = 0;
  int seq [3];
  bit v [3];
  bit took [3];
  int pv = 70, pr = 80;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at (%0d,%0d) t=%0t", tag, act, exp, mx, my, $time);
    end
  endtask

  function automatic logic [23:0] pix(input int l);
    return {8'(l), 16'(seq[l])};
  endfunction

  task automatic rect(input int l, output bit en, output int rx, output int ry, output int rw, output int rh);
    en = 0; rx = 0; ry = 0; rw = 0; rh = 0;
    if (mlay == 0) begin
      en = 1; ry = TY; rw = TW; rh = TH; rx = (l == 1) ? T1X : T2X;
    end else if (mlay == 1 && l == 1) begin
      en = 1; rw = FW; rh = FH;
    end else if (mlay == 2 && l == 2) begin
      en = 1; rw = mw2; rh = mh2;
    end
  endtask

  task automatic step();
    bit en [3];
    bit need [3];
    bit ev, efire;
    logic [23:0] ed;
    string dtag;
    int rx, ry, rw, rh;
    @(negedge clk);
    for (int l = 0; l < 3; l++) begin
      if (!v[l] || took[l]) v[l] = ($urandom % 100) < pv;
      took[l] = 0;
    end
    bg_valid = v[0]; l1_valid = v[1]; l2_valid = v[2];
    bg_data = pix(0); l1_data = pix(1); l2_data = pix(2);
    out_ready = ($urandom % 100) < pr;
    #1;
    en[0] = 1; need[0] = 1;
    for (int l = 1; l < 3; l++) begin
      rect(l, en[l], rx, ry, rw, rh);
      need[l] = en[l] && mx >= rx && mx < rx + rw && my >= ry && my < ry + rh;
    end
    ev = v[0] && (!need[1] || v[1]) && (!need[2] || v[2]);
    efire = ev && out_ready;
    if (need[2]) begin ed = pix(2); dtag = (mlay == 0) ? (need[1] ? "R3 R4 R10 R8" : "R4 R10 R8") : "R6 R10 R8"; end
    else if (need[1]) begin ed = pix(1); dtag = (mlay == 0) ? "R4 R10 R8" : "R5 R10 R8"; end
    else begin ed = pix(0); dtag = (mlay == 2) ? "R2 R6 R8" : "R2 R8"; end
    chk(out_valid == ev, "R9 out_valid", 32'(out_valid), 32'(ev));
    if (ev) chk(out_data == ed, dtag, 32'(out_data), 32'(ed));
    chk(out_sof == (mx == 0 && my == 0), "R1 sof", 32'(out_sof), 32'(mx == 0 && my == 0));
    chk(out_eof == (mx == FW - 1 && my == FH - 1), "R1 eof", 32'(out_eof), 32'(mx == FW - 1 && my == FH - 1));
    chk(bg_ready == efire, "R9 bg_ready", 32'(bg_ready), 32'(efire));
    chk(l1_ready == (en[1] ? (need[1] && efire) : 1'b1), en[1] ? "R9 l1_ready" : "R7 l1_ready",
        32'(l1_ready), 32'(en[1] ? (need[1] && efire) : 1'b1));
    chk(l2_ready == (en[2] ? (need[2] && efire) : 1'b1), en[2] ? "R9 l2_ready" : "R7 l2_ready",
        32'(l2_ready), 32'(en[2] ? (need[2] && efire) : 1'b1));
    @(posedge clk);
    took[0] = v[0] && efire;
    for (int l = 1; l < 3; l++) took[l] = v[l] && (en[l] ? (need[l] && efire) : 1'b1);
    for (int l = 0; l < 3; l++) if (took[l]) seq[l]++;
    if (mx == 0 && my == 0 && !efire) begin
      mlay = !mode_sw[0] ? 0 : (!mode_sw[1] ? 1 : 2);
      mw2 = (int'(l2_w) > FW) ? FW : int'(l2_w);
      mh2 = (int'(l2_h) > FH) ? FH : int'(l2_h);
    end
    if (efire) begin
      if (mx == FW - 1) begin mx = 0; my = (my == FH - 1) ? 0 : my + 1; end
      else mx++;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 3; l++) begin seq[l] = 0; v[l] = 0; took[l] = 0; end
    rst_n = 0; mode_sw = 2'b00; l2_w = '0; l2_h = '0; out_ready = 0;
    bg_valid = 0; l1_valid = 0; l2_valid = 0;
    bg_data = '0; l1_data = '0; l2_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // Reset state: at origin, nothing offered, nothing taken (R1, R9)
    chk(out_sof == 1'b1 && out_eof == 1'b0, "R1 reset position", 32'({out_sof, out_eof}), 32'h2);
    chk(out_valid == 1'b0 && bg_ready == 1'b0, "R9 reset idle", 32'({out_valid, bg_ready}), 32'h0);
    // Thumbnail layout with overlapping rectangles (R3, R4)
    run(1000);
    // Solo layer 1, switched mid-frame (R5, R8)
    mode_sw = 2'b01; run(900);
    // Solo layer 2, small native size (R6, R2)
    l2_w = XW'(5); l2_h = YW'(4); mode_sw = 2'b11; run(900);
    // Oversized layer 2 gets clamped (R6)
    l2_w = XW'(20); l2_h = YW'(12); run(900);
    pv = 100; pr = 100; run(400);
    // Heavy back-pressure in thumbnail (R9)
    pv = 80; pr = 30; mode_sw = 2'b00; run(1500);
    // Rapid layout toggling at arbitrary points (R8, R7)
    pr = 70;
    for (int k = 0; k < 60; k++) begin
      mode_sw = 2'(k % 4); l2_w = XW'(k % 17); l2_h = YW'(k % 9);
      run(37);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule